// File: doc/BRIEF.md
# Fractional-Increment PTP System Timer

This block is a free-running time-of-day counter for IEEE 1588 hardware timestamping. In its tunable form the counter holds nanoseconds with 19 fractional-nanosecond bits below them. A rate generator adds a programmable 24-bit step once every programmable number of clock ticks, so software can trim the clock rate in fractions of a nanosecond. In a fixed-rate build the counter instead adds exactly 8 ns on every tick. It then carries a 24-bit fractional residue below its nanosecond words, and the increment register has no effect on counting.

Software reaches the block through a 32-bit register port. A write strobe takes one cycle, and read data appears one cycle after the read strobe. Reads of the multi-word time value are coherent: reading the lowest-order word freezes a snapshot that later word reads return. Writes are also coherent: lower words are staged and the whole value loads when the high word is written. Two capture pairs record the time when a receive strobe or a transmit strobe fires. Each pair holds its value until software reads its high word.

Top module: `ptp_frac_timer`

## Requirements
- R1: After reset the counter is zero and counting. The control word reads 0. The increment word reads 0x0180_0000, which is period 1 in bits 31:24 and step 0x80_0000 (16 ns scaled by 2^19) in bits 23:0. The register addresses are: control 0, increment 1, residue 2, time low 3, time high 4, receive capture low/high 5/6, transmit capture low/high 7/8.
- R2: In tunable mode the 64-bit counter {high, low} gains the 24-bit step of increment bits 23:0 each time the period elapses.
- R3: With period P in increment bits 31:24, a step occurs once every P ticks, counted from the last write of the increment word. A period of 0 stops the counter from advancing.
- R4: Reading the lowest-order time word (low in tunable mode, residue in fixed-rate mode) latches the time words into a shadow. Reads of the higher words then return the shadow, not the live count.
- R5: A write to a lower time word is only staged and leaves the counter unchanged. A write to the high word loads the high word and all staged words into the counter together.
- R6: While control bit 31 is set, the counter holds its value. Clearing the bit resumes counting from the held value. Bit 31 reads back as written.
- R7: The counter wraps to zero at its full width with no indication.
- R8: In fixed-rate mode the counter {high, low, residue[31:8]} adds 8 ns per tick, and the increment word has no effect. The residue word reads its low 8 bits as zero. In tunable mode the residue word reads 0.
- R9: A receive or transmit strobe copies {high, low} into the matching capture pair, but only if that pair is empty. The captured value then ignores later strobes until the pair's high word is read.
- R10: Control bit 0 (receive) and bit 1 (transmit) flag a full capture pair. A flag clears on the read of its pair's high word and not on the low word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register word address |
| reg_wr_i | input | 1 | Single-cycle write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| rx_stamp_i | input | 1 | Receive timestamp strobe |
| tx_stamp_i | input | 1 | Transmit timestamp strobe |

## Verification
The bench builds two copies of the block. One copy uses the tunable default (FIXED_RATE=0) and is loaded close to the 64-bit wrap point. There it runs with small steps, a period of 3 and a period of 0, so the carry into the high word and the wrap to zero occur within a few cycles. The other copy uses FIXED_RATE=1 and is loaded just below a low-word carry with a nonzero residue. This exposes the 8 ns step, the zeroed residue byte and the residue-triggered snapshot. Both copies share one register bus, so an increment write that steers the tunable copy must leave the fixed-rate copy's count unchanged.

// File: rtl/ptp_tmr_pkg.sv
package ptp_tmr_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int PER_W    = 8;
  localparam int INC_W    = 24;
  localparam int RES_W    = 24;
  localparam int NUM_CAP  = 2;
  localparam int CAP_RX   = 0;
  localparam int CAP_TX   = 1;
  localparam int HALT_BIT = 31;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 4'd0,
    REG_INCR = 4'd1,
    REG_TRES = 4'd2,
    REG_TLO  = 4'd3,
    REG_THI  = 4'd4,
    REG_RXLO = 4'd5,
    REG_RXHI = 4'd6,
    REG_TXLO = 4'd7,
    REG_TXHI = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/ptp_tmr_rate.sv
module ptp_tmr_rate #(
  parameter int PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PER_W-1:0] period_i,
  output logic             step_o
);
  logic [PER_W-1:0] tick_q;
  logic [PER_W-1:0] period_m1;
  logic             per_ok;

  assign per_ok    = (period_i != '0);
  assign period_m1 = period_i - PER_W'(1);
  assign step_o    = run_i && per_ok && (tick_q >= period_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             tick_q <= '0;
    else if (restart_i)      tick_q <= '0;
    else if (run_i && per_ok) tick_q <= step_o ? '0 : tick_q + PER_W'(1);
  end

  // R3
  period_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o && (period_i > PER_W'(1)) && !restart_i |=> !step_o);
endmodule

// File: rtl/ptp_tmr_count.sv
module ptp_tmr_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] step_val_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (step_i) cnt_o <= cnt_o + step_val_i;
  end

  // R5
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !load_i |=> $stable(cnt_o));
  // R7
  wrap_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> cnt_o == $past(cnt_o) + $past(step_val_i));
endmodule

// File: rtl/ptp_tmr_cap.sv
module ptp_tmr_cap #(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              release_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] cap_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o   <= '0;
      valid_o <= 1'b0;
    end else if (valid_o) begin
      if (release_i) valid_o <= 1'b0;
    end else if (strobe_i) begin
      cap_o   <= time_i;
      valid_o <= 1'b1;
    end
  end

  // R9
  cap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && strobe_i |=> valid_o && cap_o == $past(time_i));
  // R9
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !release_i |=> valid_o && $stable(cap_o));
  // R10
  cap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && release_i |=> !valid_o);
endmodule

// File: rtl/ptp_frac_timer.sv
module ptp_frac_timer
  import ptp_tmr_pkg::*;
#(
  parameter bit          FIXED_RATE    = 1'b0,
  parameter int          FIXED_STEP_NS = 8,
  parameter logic [31:0] INCR_RST      = 32'h0180_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic              rx_stamp_i,
  input  logic              tx_stamp_i
);
  localparam int RES_OFS = FIXED_RATE ? RES_W : 0;
  localparam int CNT_W   = 2*WORD_W + RES_OFS;
  localparam int TIME_W  = 2*WORD_W;
  localparam logic [CNT_W-1:0]  FIX_STEP = CNT_W'(FIXED_STEP_NS) << RES_OFS;
  localparam logic [ADDR_W-1:0] LOW_ADDR = FIXED_RATE ? ADDR_W'(REG_TRES) : ADDR_W'(REG_TLO);

  reg_addr_e addr;
  assign addr = reg_addr_e'(reg_addr_i);

  logic wr_ctrl, wr_incr, wr_tlo, wr_thi, rd_low;
  assign wr_ctrl = reg_wr_i && (addr == REG_CTRL);
  assign wr_incr = reg_wr_i && (addr == REG_INCR);
  assign wr_tlo  = reg_wr_i && (addr == REG_TLO);
  assign wr_thi  = reg_wr_i && (addr == REG_THI);
  assign rd_low  = reg_rd_i && (reg_addr_i == LOW_ADDR);

  logic              halt_q;
  logic [WORD_W-1:0] incr_q;
  logic [WORD_W-1:0] stage_lo_q;
  logic [TIME_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q     <= 1'b0;
      incr_q     <= INCR_RST;
      stage_lo_q <= '0;
      shadow_q   <= '0;
    end else begin
      if (wr_ctrl) halt_q     <= reg_wdata_i[HALT_BIT];
      if (wr_incr) incr_q     <= reg_wdata_i;
      if (wr_tlo)  stage_lo_q <= reg_wdata_i;
      if (rd_low)  shadow_q   <= {live_hi, live_lo};
    end
  end

  // Counter and its step source
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  step_val;
  logic [CNT_W-1:0]  load_val;
  logic              step;
  logic [WORD_W-1:0] live_lo, live_hi, res_word;

  assign live_lo = cnt[RES_OFS +: WORD_W];
  assign live_hi = cnt[RES_OFS+WORD_W +: WORD_W];

  generate
    if (FIXED_RATE) begin : g_fixed
      logic [RES_W-1:0] stage_res_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_res_q <= '0;
        else if (reg_wr_i && (addr == REG_TRES))
          stage_res_q <= reg_wdata_i[WORD_W-1 -: RES_W];
      end
      assign step     = !halt_q;
      assign step_val = FIX_STEP;
      assign load_val = {reg_wdata_i, stage_lo_q, stage_res_q};
      assign res_word = {cnt[RES_W-1:0], {(WORD_W-RES_W){1'b0}}};
    end else begin : g_tune
      ptp_tmr_rate #(.PER_W(PER_W)) u_rate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (!halt_q),
        .restart_i (wr_incr),
        .period_i  (incr_q[WORD_W-1 -: PER_W]),
        .step_o    (step)
      );
      assign step_val = CNT_W'(incr_q[INC_W-1:0]);
      assign load_val = {reg_wdata_i, stage_lo_q};
      assign res_word = '0;
    end
  endgenerate

  ptp_tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .step_val_i (step_val),
    .load_i     (wr_thi),
    .load_val_i (load_val),
    .cnt_o      (cnt)
  );

  // Capture pairs
  logic [NUM_CAP-1:0] cap_strobe, cap_rel, cap_valid;
  logic [TIME_W-1:0]  cap_q [NUM_CAP];

  assign cap_strobe[CAP_RX] = rx_stamp_i;
  assign cap_strobe[CAP_TX] = tx_stamp_i;

  generate
    for (genvar g = 0; g < NUM_CAP; g++) begin : g_cap
      localparam reg_addr_e HI_SEL = (g == CAP_RX) ? REG_RXHI : REG_TXHI;
      assign cap_rel[g] = reg_rd_i && (addr == HI_SEL);
      ptp_tmr_cap #(.TIME_W(TIME_W)) u_cap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .strobe_i  (cap_strobe[g]),
        .release_i (cap_rel[g]),
        .time_i    ({live_hi, live_lo}),
        .cap_o     (cap_q[g]),
        .valid_o   (cap_valid[g])
      );
    end
  endgenerate

  // Read path
  logic [WORD_W-1:0] rd_val;
  always_comb begin
    case (addr)
      REG_CTRL: rd_val = {halt_q, {(WORD_W-1-NUM_CAP){1'b0}}, cap_valid};
      REG_INCR: rd_val = incr_q;
      REG_TRES: rd_val = res_word;
      REG_TLO:  rd_val = (reg_addr_i == LOW_ADDR) ? live_lo : shadow_q[WORD_W-1:0];
      REG_THI:  rd_val = shadow_q[TIME_W-1 -: WORD_W];
      REG_RXLO: rd_val = cap_q[CAP_RX][WORD_W-1:0];
      REG_RXHI: rd_val = cap_q[CAP_RX][TIME_W-1 -: WORD_W];
      REG_TXLO: rd_val = cap_q[CAP_TX][WORD_W-1:0];
      REG_TXHI: rd_val = cap_q[CAP_TX][TIME_W-1 -: WORD_W];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_val;
  end

  // R8
  res_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && (addr == REG_TRES) |=> reg_rdata_o[WORD_W-RES_W-1:0] == '0);
  // R4
  snap_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_low |=> shadow_q[TIME_W-1 -: WORD_W] == $past(live_hi));
endmodule

// File: tb/sim_ptp_frac_timer.sv
module sim_ptp_frac_timer;
  localparam logic [1:0] OP_IDLE = 2'd0;
  localparam logic [1:0] OP_WR   = 2'd1;
  localparam logic [1:0] OP_RD   = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // Tunable copy, counter stepping from reset; each row is one clock
  localparam vec_t VEC [42] = '{
    '{OP_RD,   4'd3, 32'h0,        32'h0,        8'd1},  // R1 time low
    '{OP_RD,   4'd4, 32'h0,        32'h0,        8'd1},  // R1 time high
    '{OP_RD,   4'd0, 32'h0,        32'h0,        8'd1},  // R1 control
    '{OP_RD,   4'd1, 32'h0,        32'h0180_0000, 8'd1}, // R1 increment default
    '{OP_RD,   4'd3, 32'h0,        32'h0200_0000, 8'd2}, // R2 four steps
    '{OP_WR,   4'd0, 32'h8000_0000, 32'h0,       8'd6},  // R6 halt
    '{OP_RD,   4'd3, 32'h0,        32'h0300_0000, 8'd6},
    '{OP_RD,   4'd3, 32'h0,        32'h0300_0000, 8'd6},
    '{OP_WR,   4'd3, 32'hFFFF_FF00, 32'h0,       8'd5},  // R5 stage
    '{OP_RD,   4'd3, 32'h0,        32'h0300_0000, 8'd5},
    '{OP_WR,   4'd4, 32'hFFFF_FFFF, 32'h0,       8'd5},  // R5 commit
    '{OP_RD,   4'd3, 32'h0,        32'hFFFF_FF00, 8'd5},
    '{OP_RD,   4'd4, 32'h0,        32'hFFFF_FFFF, 8'd5},
    '{OP_WR,   4'd1, 32'h0100_0080, 32'h0,       8'd2},
    '{OP_WR,   4'd0, 32'h0,        32'h0,        8'd6},  // R6 resume
    '{OP_RD,   4'd3, 32'h0,        32'hFFFF_FF00, 8'd6},
    '{OP_RD,   4'd3, 32'h0,        32'hFFFF_FF80, 8'd2},
    '{OP_RD,   4'd3, 32'h0,        32'h0,        8'd7},  // R7 wrap
    '{OP_RD,   4'd4, 32'h0,        32'h0,        8'd7},
    '{OP_RD,   4'd3, 32'h0,        32'h0000_0100, 8'd2},
    '{OP_WR,   4'd0, 32'h8000_0000, 32'h0,       8'd6},
    '{OP_WR,   4'd3, 32'hFFFF_FFC0, 32'h0,       8'd5},
    '{OP_WR,   4'd4, 32'h0000_0005, 32'h0,       8'd5},
    '{OP_WR,   4'd1, 32'h0100_0040, 32'h0,       8'd2},
    '{OP_RD,   4'd3, 32'h0,        32'hFFFF_FFC0, 8'd4}, // R4 snapshot
    '{OP_WR,   4'd0, 32'h0,        32'h0,        8'd6},
    '{OP_IDLE, 4'd0, 32'h0,        32'h0,        8'd0},
    '{OP_RD,   4'd4, 32'h0,        32'h0000_0005, 8'd4}, // shadow, live is 6
    '{OP_RD,   4'd3, 32'h0,        32'h0000_0040, 8'd4},
    '{OP_RD,   4'd4, 32'h0,        32'h0000_0006, 8'd4},
    '{OP_WR,   4'd1, 32'h0300_0100, 32'h0,       8'd3},  // R3 period 3
    '{OP_RD,   4'd3, 32'h0,        32'h0000_0100, 8'd3},
    '{OP_RD,   4'd3, 32'h0,        32'h0000_0100, 8'd3},
    '{OP_RD,   4'd3, 32'h0,        32'h0000_0100, 8'd3},
    '{OP_RD,   4'd3, 32'h0,        32'h0000_0200, 8'd3},
    '{OP_RD,   4'd3, 32'h0,        32'h0000_0200, 8'd3},
    '{OP_RD,   4'd3, 32'h0,        32'h0000_0200, 8'd3},
    '{OP_RD,   4'd3, 32'h0,        32'h0000_0300, 8'd3},
    '{OP_WR,   4'd1, 32'h0000_0100, 32'h0,       8'd3},  // R3 period 0
    '{OP_IDLE, 4'd0, 32'h0,        32'h0,        8'd0},
    '{OP_IDLE, 4'd0, 32'h0,        32'h0,        8'd0},
    '{OP_RD,   4'd3, 32'h0,        32'h0000_0300, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic        rx_stb = 1'b0, tx_stb = 1'b0;
  logic [31:0] rdata0, rdata1;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ptp_frac_timer #(.FIXED_RATE(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rd_i(rd), .reg_rdata_o(rdata0),
    .rx_stamp_i(rx_stb), .tx_stamp_i(tx_stb));

  ptp_frac_timer #(.FIXED_RATE(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rd_i(rd), .reg_rdata_o(rdata1),
    .rx_stamp_i(rx_stb), .tx_stamp_i(tx_stb));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [3:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr    = (op == OP_WR);
    rd    = (op == OP_RD);
    @(negedge clk);
    wr = 1'b0;
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    do_op(OP_WR, a, d);
  endtask

  task automatic rd0(input string req, input logic [3:0] a, input logic [31:0] exp);
    do_op(OP_RD, a, '0);
    check(req, rdata0, exp);
  endtask

  task automatic rd1(input string req, input logic [3:0] a, input logic [31:0] exp);
    do_op(OP_RD, a, '0);
    check(req, rdata1, exp);
  endtask

  task automatic pulse(input logic rx, input logic tx);
    rx_stb = rx;
    tx_stb = tx;
    @(negedge clk);
    rx_stb = 1'b0;
    tx_stb = 1'b0;
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    reset_dut();
    for (int i = 0; i < 42; i++) begin
      do_op(VEC[i].op, VEC[i].addr, VEC[i].data);
      if (VEC[i].op == OP_RD) begin
        checks++;
        if (rdata0 !== VEC[i].exp) begin
          errors++;
          $display("FAIL R%0d row %0d got %h expected %h", VEC[i].req, i, rdata0, VEC[i].exp);
        end
      end
    end

    // R9 / R10 capture pairs, counter halted at known values
    wr_reg(4'd0, 32'h8000_0000);
    wr_reg(4'd3, 32'h1111_2222);
    wr_reg(4'd4, 32'h0000_3333);
    pulse(1'b1, 1'b0);
    rd0("R10 rx flag set", 4'd0, 32'h8000_0001);
    wr_reg(4'd3, 32'h4444_5555);
    wr_reg(4'd4, 32'h0000_6666);
    pulse(1'b1, 1'b0);
    rd0("R9 rx low held", 4'd5, 32'h1111_2222);
    rd0("R10 low read keeps flag", 4'd0, 32'h8000_0001);
    rd0("R9 rx high held", 4'd6, 32'h0000_3333);
    rd0("R10 rx flag cleared", 4'd0, 32'h8000_0000);
    pulse(1'b1, 1'b0);
    rd0("R9 rx rearmed", 4'd5, 32'h4444_5555);
    pulse(1'b0, 1'b1);
    rd0("R10 both flags", 4'd0, 32'h8000_0003);
    rd0("R9 tx low", 4'd7, 32'h4444_5555);
    rd0("R9 tx high", 4'd8, 32'h0000_6666);
    rd0("R10 tx flag cleared", 4'd0, 32'h8000_0001);

    // R1 reset returns everything to default
    reset_dut();
    rd0("R1 low after reset", 4'd3, 32'h0);
    rd0("R1 control after reset", 4'd0, 32'h0);
    rd0("R1 increment after reset", 4'd1, 32'h0180_0000);

    // R8 fixed-rate copy
    wr_reg(4'd0, 32'h8000_0000);
    wr_reg(4'd2, 32'h1234_56AB);
    wr_reg(4'd3, 32'hFFFF_FFF8);
    wr_reg(4'd4, 32'h0000_0007);
    wr_reg(4'd1, 32'h0100_0001);
    do_op(OP_RD, 4'd2, '0);
    check("R8 residue low byte zero", rdata1, 32'h1234_5600);
    check("R8 tunable residue reads zero", rdata0, 32'h0);
    rd1("R4 fixed high shadow", 4'd4, 32'h0000_0007);
    wr_reg(4'd0, 32'h0);
    rd1("R8 residue snapshot", 4'd2, 32'h1234_5600);
    rd1("R4 fixed low from shadow", 4'd3, 32'hFFFF_FFF8);
    rd1("R4 fixed high from shadow", 4'd4, 32'h0000_0007);
    rd1("R8 residue untouched by step", 4'd2, 32'h1234_5600);
    rd1("R8 three 8 ns steps", 4'd3, 32'h0000_0010);
    rd1("R8 carry into high", 4'd4, 32'h0000_0008);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule